// File: doc/BRIEF.md
# Masked Configuration Register Space

This block holds a 256-byte configuration register space in which every byte carries its own write mask, so a write can only change the bits that the mask allows. Software-facing logic reaches it through one access port. That port reads or writes 1, 2 or 4 bytes at any byte address. Byte order is little-endian: the low byte of the data goes to the lowest address.

Up to six base address regions and one expansion ROM region can be registered at run time. Each registration gives a power-of-two size and a small type code. It derives the write mask of that region's 32-bit register from the size and loads the type code into the register. A size that is not a power of two is refused and flagged.

Any write that alters a base address register, or alters the I/O or memory decode enable in the command byte, raises a one-cycle remap pulse. Address decode logic uses that pulse to re-evaluate its windows.

Top module: `cfg_space`

## Requirements
- R1: After reset every byte of the space reads 0, all region masks are 0, and `remap_o` and `reg_err_o` are low.
- R2: A write of L bytes at address A (L = 1 for size code 0, 2 for code 1, 4 for codes 2 and 3) updates bytes A to A+L-1. Byte k of the range takes data bits [8k+7:8k]. Bytes that would fall past 0xFF are dropped; they never wrap to 0x00.
- R3: Every written byte becomes (old AND NOT mask) OR (data AND mask). In the command byte at 0x04 only bits 0 (I/O decode), 1 (memory decode) and 2 (bus master) are writable. Bytes 0x00-0x03, 0x05-0x0B, 0x0D-0x0F, 0x28-0x2F and 0x34-0x3B and 0x3D-0x3F are read-only.
- R4: Bytes 0x0C and 0x3C, and every byte from 0x40 to 0xFF, are fully writable.
- R5: Registering region index n (0 to 5) with a valid size S and type T sets the write mask of the 32-bit register at 0x10 + 4n to NOT(S-1). It also loads that register with T in bits [3:0] and zeros above.
- R6: Registering index 6 targets the expansion ROM register at 0x30. Its mask is NOT(S-1) with bit 0 also writable as the ROM enable.
- R7: A registration whose size is zero or not a power of two changes no mask and no register. It drives `reg_err_o` high for the one cycle after the request. A valid registration leaves `reg_err_o` low.
- R8: A read returns 4 bytes when size code 2 or 3 is used and the address is at most 0xFC. It returns 2 bytes when size code 1 or a 4-byte code is used and the address is at most 0xFE. Otherwise it returns 1 byte. Bytes above the returned width read as 0.
- R9: `remap_o` is high in the cycle after a write that changes any byte in 0x10-0x27, or changes command bit 0 or bit 1. A write that changes nothing there, changes only command bit 2, or changes only the ROM register leaves it low.
- R10: A registration accepted in the same cycle as a write takes precedence, and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the access port |
| acc_addr_i | input | 8 | Byte address for reads and writes |
| acc_size_i | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| wr_data_i | input | 32 | Write data, little-endian |
| rd_data_o | output | 32 | Read data for the current address and size |
| remap_o | output | 1 | One-cycle pulse after a write that affects address decoding |
| reg_en_i | input | 1 | Region registration request |
| reg_idx_i | input | 3 | Region index: 0-5 base address, 6 expansion ROM |
| reg_size_i | input | 32 | Region size in bytes, power of two |
| reg_type_i | input | 4 | Type bits loaded into the register's low nibble |
| reg_err_o | output | 1 | One-cycle pulse after a refused registration |

## Verification
The merge rule is checked with all-ones patterns, which show the mask exactly. A byte that reads zero is read-only, and the ones are the writable bits. Mixed-value patterns such as 0x11223344 show lane order and the read width fallback, because each byte is distinct. The patterns also hit the top of the space, to show that writes are clipped and reads are narrowed. The region masks are probed by all-ones writes after registration. An I/O-type region shows that the type nibble survives below the mask. Remap detection is checked with writes that change decode bits and writes that re-store the same value. A write that touches only command bit 2 or the ROM register must leave the pulse low.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  localparam int unsigned CFG_BYTES  = 256;
  localparam int unsigned CFG_AW     = 8;
  localparam int unsigned CFG_LANES  = 4;
  localparam int unsigned CFG_DW     = 8 * CFG_LANES;
  localparam int unsigned NUM_REGION = 7;
  localparam int unsigned ROM_IDX    = 6;
  localparam int unsigned IDX_W      = 3;
  localparam int unsigned TYPE_W     = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } acc_size_e;

  localparam logic [7:0] CMD_ADDR   = 8'h04;
  localparam logic [7:0] CLS_ADDR   = 8'h0C;
  localparam logic [7:0] BAR_LO     = 8'h10;
  localparam logic [7:0] BAR_HI     = 8'h27;
  localparam logic [7:0] ROM_ADDR   = 8'h30;
  localparam logic [7:0] ILINE_ADDR = 8'h3C;
  localparam logic [7:0] DEV_LO     = 8'h40;

  // mask of bytes outside the registrable regions
  function automatic logic [7:0] fixed_mask(input logic [7:0] a);
    if (a == CMD_ADDR)                        return 8'h07;
    else if (a == CLS_ADDR || a == ILINE_ADDR) return 8'hFF;
    else if (a >= DEV_LO)                     return 8'hFF;
    else                                      return 8'h00;
  endfunction
endpackage

// File: rtl/cfg_region_mask.sv
module cfg_region_mask
  import cfg_space_pkg::*;
#(
  parameter int unsigned AW      = CFG_AW,
  parameter int unsigned LANES   = CFG_LANES,
  parameter int unsigned DW      = CFG_DW,
  parameter int unsigned NREG    = NUM_REGION,
  parameter int unsigned ROM_SEL = ROM_IDX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_en_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [DW-1:0]     reg_size_i,
  input  logic [AW-1:0]     lane_addr_i [LANES],
  output logic [7:0]        lane_mask_o [LANES],
  output logic              reg_ok_o,
  output logic              reg_err_o
);
  logic [DW-1:0] mask_q [NREG];
  logic          size_ok, idx_ok;

  assign size_ok  = (reg_size_i != '0) && ((reg_size_i & (reg_size_i - 1'b1)) == '0);
  assign idx_ok   = 32'(reg_idx_i) < NREG;
  assign reg_ok_o = reg_en_i && size_ok && idx_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_err_o <= 1'b0;
      for (int i = 0; i < int'(NREG); i++) mask_q[i] <= '0;
    end else begin
      reg_err_o <= reg_en_i && idx_ok && !size_ok;
      if (reg_ok_o)
        mask_q[reg_idx_i] <= ~(reg_size_i - 1'b1) |
                             DW'(32'(reg_idx_i) == ROM_SEL);
    end
  end

  for (genvar k = 0; k < int'(LANES); k++) begin : g_lane
    logic [AW-1:0] off;
    assign off = lane_addr_i[k] - AW'(BAR_LO);
    always_comb begin
      lane_mask_o[k] = fixed_mask(lane_addr_i[k]);
      if (lane_addr_i[k] >= BAR_LO && lane_addr_i[k] <= BAR_HI)
        lane_mask_o[k] = mask_q[off[4:2]][{lane_addr_i[k][1:0], 3'b000} +: 8];
      else if (lane_addr_i[k][AW-1:2] == ROM_ADDR[AW-1:2])
        lane_mask_o[k] = mask_q[ROM_SEL][{lane_addr_i[k][1:0], 3'b000} +: 8];
    end
  end

  AST_ERR_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_err_o |-> $past(reg_en_i)); // R7

  for (genvar r = 0; r < int'(NREG); r++) begin : g_chk
    AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(reg_en_i) || reg_err_o) |-> $stable(mask_q[r])); // R7
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_space_pkg::*;
#(
  parameter int unsigned BYTES = CFG_BYTES,
  parameter int unsigned AW    = CFG_AW,
  parameter int unsigned LANES = CFG_LANES,
  parameter int unsigned DW    = CFG_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lane_act_i  [LANES],
  input  logic [AW-1:0] lane_addr_i [LANES],
  input  logic [7:0]    lane_mask_i [LANES],
  input  logic [DW-1:0] wr_data_i,
  input  logic          init_en_i,
  input  logic [AW-1:0] init_addr_i,
  input  logic [DW-1:0] init_word_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [1:0]    rd_size_i,
  output logic [DW-1:0] rd_data_o,
  output logic          remap_hit_o
);
  localparam logic [AW-1:0] LAST4 = AW'(BYTES - 4);
  localparam logic [AW-1:0] LAST2 = AW'(BYTES - 2);

  logic [7:0] mem_q  [BYTES];
  logic [7:0] merged [LANES];
  logic [LANES-1:0] hit;

  for (genvar k = 0; k < int'(LANES); k++) begin : g_merge
    logic [7:0] old_b;
    assign old_b     = mem_q[lane_addr_i[k]];
    assign merged[k] = (old_b & ~lane_mask_i[k]) | (wr_data_i[8*k +: 8] & lane_mask_i[k]);
    always_comb begin
      hit[k] = 1'b0;
      if (lane_act_i[k]) begin
        if (lane_addr_i[k] >= BAR_LO && lane_addr_i[k] <= BAR_HI)
          hit[k] = (merged[k] != old_b);
        else if (lane_addr_i[k] == CMD_ADDR)
          hit[k] = ((merged[k] ^ old_b) & 8'h03) != 8'h00;
      end
    end
  end
  assign remap_hit_o = |hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(BYTES); i++) mem_q[i] <= 8'h00;
    end else if (init_en_i) begin
      for (int k = 0; k < int'(LANES); k++)
        mem_q[init_addr_i + AW'(k)] <= init_word_i[8*k +: 8];
    end else begin
      for (int k = 0; k < int'(LANES); k++)
        if (lane_act_i[k]) mem_q[lane_addr_i[k]] <= merged[k];
    end
  end

  // width fallback at the top of the space
  logic w4, w2;
  assign w4 = rd_size_i[1] && (rd_addr_i <= LAST4);
  assign w2 = !w4 && (rd_size_i != SZ_BYTE) && (rd_addr_i <= LAST2);

  always_comb begin
    rd_data_o        = '0;
    rd_data_o[7:0]   = mem_q[rd_addr_i];
    if (w2 || w4) rd_data_o[15:8] = mem_q[rd_addr_i + AW'(1)];
    if (w4) begin
      rd_data_o[23:16] = mem_q[rd_addr_i + AW'(2)];
      rd_data_o[31:24] = mem_q[rd_addr_i + AW'(3)];
    end
  end

  AST_RO_ID_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(mem_q[0])); // R3
  AST_CMD_UPPER_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(mem_q[4][7:3])); // R3
endmodule

// File: rtl/cfg_space.sv
module cfg_space
  import cfg_space_pkg::*;
#(
  parameter int unsigned AW    = CFG_AW,
  parameter int unsigned LANES = CFG_LANES,
  parameter int unsigned DW    = CFG_DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     acc_addr_i,
  input  logic [1:0]        acc_size_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              remap_o,
  input  logic              reg_en_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [DW-1:0]     reg_size_i,
  input  logic [TYPE_W-1:0] reg_type_i,
  output logic              reg_err_o
);
  logic          lane_act  [LANES];
  logic [AW-1:0] lane_addr [LANES];
  logic [7:0]    lane_mask [LANES];
  logic [2:0]    len;
  logic          reg_ok, remap_hit;
  logic [AW-1:0] init_addr;

  always_comb begin
    case (acc_size_i)
      SZ_BYTE: len = 3'd1;
      SZ_HALF: len = 3'd2;
      default: len = 3'd4;
    endcase
  end

  for (genvar k = 0; k < int'(LANES); k++) begin : g_lane
    logic [AW:0] sum;
    assign sum          = {1'b0, acc_addr_i} + (AW+1)'(k);
    assign lane_addr[k] = sum[AW-1:0];
    assign lane_act[k]  = wr_en_i && !reg_ok && (3'(k) < len) && !sum[AW];
  end

  assign init_addr = (32'(reg_idx_i) == ROM_IDX) ? AW'(ROM_ADDR)
                                                 : AW'(BAR_LO) + AW'({reg_idx_i, 2'b00});

  cfg_region_mask #(.AW(AW), .LANES(LANES), .DW(DW)) u_mask (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_en_i    (reg_en_i),
    .reg_idx_i   (reg_idx_i),
    .reg_size_i  (reg_size_i),
    .lane_addr_i (lane_addr),
    .lane_mask_o (lane_mask),
    .reg_ok_o    (reg_ok),
    .reg_err_o   (reg_err_o)
  );

  cfg_store #(.AW(AW), .LANES(LANES), .DW(DW)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lane_act_i  (lane_act),
    .lane_addr_i (lane_addr),
    .lane_mask_i (lane_mask),
    .wr_data_i   (wr_data_i),
    .init_en_i   (reg_ok),
    .init_addr_i (init_addr),
    .init_word_i (DW'(reg_type_i)),
    .rd_addr_i   (acc_addr_i),
    .rd_size_i   (acc_size_i),
    .rd_data_o   (rd_data_o),
    .remap_hit_o (remap_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) remap_o <= 1'b0;
    else         remap_o <= remap_hit;
  end

  AST_REMAP_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remap_o |-> $past(wr_en_i)); // R9
  AST_REG_DROPS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remap_o |-> !$past(reg_en_i && reg_err_o == 1'b0 && reg_size_i != '0 &&
                       (reg_size_i & (reg_size_i - 1'b1)) == '0 && reg_idx_i != 3'd7)); // R10
endmodule

// File: tb/cfg_space_bench.sv
module cfg_space_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        remap;
  logic        reg_en = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_size = '0;
  logic [3:0]  reg_type = '0;
  logic        reg_err;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_space u_cfg_space (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .acc_addr_i(addr),
    .acc_size_i(size), .wr_data_i(wdata), .rd_data_o(rdata), .remap_o(remap),
    .reg_en_i(reg_en), .reg_idx_i(reg_idx), .reg_size_i(reg_size),
    .reg_type_i(reg_type), .reg_err_o(reg_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d,
                    output logic rm);
    @(negedge clk);
    wr_en = 1'b1; addr = a; size = s; wdata = d;
    @(negedge clk);
    rm = remap;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b0; addr = a; size = s;
    #1 d = rdata;
  endtask

  task automatic regn(input logic [2:0] i, input logic [31:0] sz, input logic [3:0] t,
                      output logic e);
    @(negedge clk);
    reg_en = 1'b1; reg_idx = i; reg_size = sz; reg_type = t;
    @(negedge clk);
    e = reg_err;
    reg_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, 2'd2, d); chk("R1 byte0 word", d, 32'h0);
    rd(8'h10, 2'd2, d); chk("R1 bar0 word", d, 32'h0);
    chk("R1 remap low", 32'(remap), 32'h0);
    chk("R1 err low", 32'(reg_err), 32'h0);
  endtask

  task automatic t_command();
    logic [31:0] d; logic rm;
    wr(8'h04, 2'd0, 32'hFF, rm);
    chk("R9 cmd decode change", 32'(rm), 32'h1);
    rd(8'h04, 2'd0, d); chk("R3 cmd mask", d, 32'h07);
    wr(8'h04, 2'd0, 32'h07, rm);
    chk("R9 cmd unchanged", 32'(rm), 32'h0);
    wr(8'h04, 2'd0, 32'h03, rm);
    chk("R9 cmd bit2 only", 32'(rm), 32'h0);
    rd(8'h04, 2'd0, d); chk("R3 cmd bit2 cleared", d, 32'h03);
    wr(8'h00, 2'd2, 32'hDEADBEEF, rm);
    rd(8'h00, 2'd2, d); chk("R3 id bytes read-only", d, 32'h0);
  endtask

  task automatic t_open_bytes();
    logic [31:0] d; logic rm;
    wr(8'h0C, 2'd0, 32'hA5, rm);
    rd(8'h0C, 2'd0, d); chk("R4 byte 0x0C", d, 32'hA5);
    wr(8'h3C, 2'd0, 32'h5B, rm);
    rd(8'h3C, 2'd0, d); chk("R4 byte 0x3C", d, 32'h5B);
    wr(8'h0B, 2'd1, 32'h5A66, rm);
    rd(8'h0B, 2'd1, d); chk("R2 r3_ split lanes", d, 32'h5A00);
    wr(8'h40, 2'd2, 32'h11223344, rm);
    rd(8'h40, 2'd0, d); chk("R2 lane0", d, 32'h44);
    rd(8'h43, 2'd0, d); chk("R2 lane3", d, 32'h11);
    rd(8'h41, 2'd1, d); chk("R8 half read", d, 32'h2233);
    rd(8'h40, 2'd3, d); chk("R8 code3 word", d, 32'h11223344);
    chk("R4 remap stays low", 32'(rm), 32'h0);
  endtask

  task automatic t_top_edge();
    logic [31:0] d; logic rm;
    wr(8'hFE, 2'd2, 32'hAABBCCDD, rm);
    rd(8'hFE, 2'd0, d); chk("R2 byte FE", d, 32'hDD);
    rd(8'hFF, 2'd0, d); chk("R2 byte FF", d, 32'hCC);
    rd(8'h00, 2'd0, d); chk("R2 no wrap", d, 32'h00);
    rd(8'hFE, 2'd2, d); chk("R8 word at FE", d, 32'hCCDD);
    rd(8'hFF, 2'd2, d); chk("R8 word at FF", d, 32'hCC);
    rd(8'hFC, 2'd2, d); chk("R8 word at FC", d, 32'hCCDD0000);
  endtask

  task automatic t_regions();
    logic [31:0] d; logic rm; logic e;
    regn(3'd0, 32'h100, 4'h0, e); chk("R7 good size no err", 32'(e), 32'h0);
    rd(8'h10, 2'd2, d); chk("R5 bar0 type", d, 32'h0);
    wr(8'h10, 2'd2, 32'hFFFFFFFF, rm);
    chk("R9 bar0 change", 32'(rm), 32'h1);
    rd(8'h10, 2'd2, d); chk("R5 bar0 mask", d, 32'hFFFFFF00);
    regn(3'd1, 32'h10, 4'h1, e);
    rd(8'h14, 2'd2, d); chk("R5 bar1 type", d, 32'h1);
    wr(8'h14, 2'd2, 32'hFFFFFFFF, rm);
    rd(8'h14, 2'd2, d); chk("R5 bar1 masked", d, 32'hFFFFFFF1);
    wr(8'h18, 2'd2, 32'h12345678, rm);
    chk("R9 unregistered no change", 32'(rm), 32'h0);
    rd(8'h18, 2'd2, d); chk("R5 bar2 read-only", d, 32'h0);
    regn(3'd6, 32'h800, 4'h0, e);
    wr(8'h30, 2'd2, 32'hFFFFFFFF, rm);
    chk("R9 rom no remap", 32'(rm), 32'h0);
    rd(8'h30, 2'd2, d); chk("R6 rom mask", d, 32'hFFFFF801);
  endtask

  task automatic t_bad_size();
    logic [31:0] d; logic rm; logic e;
    regn(3'd2, 32'h300, 4'h1, e); chk("R7 non pow2 err", 32'(e), 32'h1);
    rd(8'h18, 2'd2, d); chk("R7 word untouched", d, 32'h0);
    wr(8'h18, 2'd2, 32'hFFFFFFFF, rm);
    rd(8'h18, 2'd2, d); chk("R7 mask untouched", d, 32'h0);
    regn(3'd3, 32'h0, 4'h0, e); chk("R7 zero size err", 32'(e), 32'h1);
    regn(3'd3, 32'h4, 4'h0, e); chk("R7 err clears", 32'(e), 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    @(negedge clk);
    reg_en = 1'b1; reg_idx = 3'd4; reg_size = 32'h20; reg_type = 4'h8;
    wr_en = 1'b1; addr = 8'h50; size = 2'd0; wdata = 32'h77;
    @(negedge clk);
    reg_en = 1'b0; wr_en = 1'b0;
    rd(8'h50, 2'd0, d); chk("R10 write dropped", d, 32'h0);
    rd(8'h20, 2'd2, d); chk("R10 registration done", d, 32'h8);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_command();
    t_open_bytes();
    t_top_edge();
    t_regions();
    t_bad_size();
    t_collision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule